// File: doc/BRIEF.md
# Variable Bus Cycle Length Controller

This block decides how many master clock periods each processor bus cycle lasts. A bus cycle can last 6, 8 or 12 master clocks. The block counts master clocks through the current bus cycle and raises a one-clock completion strobe in its final clock. The next bus cycle begins in the clock right after the strobe.

The length is chosen when each bus cycle begins. The inputs that pick it are:
- a flag for internal cycles that touch no memory;
- a two-bit region code, already decoded elsewhere;
- the 24-bit address;
- a fast-ROM enable bit held in a one-bit register that software can write.

A separate pause request adds a fixed stall of 40 master clocks to the bus cycle in progress. During the stall the clock count does not move and the strobe stays low.

A bus cycle is in its first clock right after reset and in the clock after every completion strobe. In that first clock the block samples the length inputs and latches the chosen length. The latched length holds until the strobe.

Top module: `bus_cycle_timer`

## Requirements
- R1: During reset `cycle_done` is 0 and `fast_rom_en` reads 0. After reset a ROM access at address 0x800000 or above lasts 8 master clocks until the enable bit is written to 1.
- R2: When `bus_internal` is 1 the bus cycle lasts 6 master clocks, whatever the region, address and enable bit.
- R3: A ROM access (region code 2'b00) lasts 6 master clocks when `fast_rom_en` is 1 and the address is 0x800000 or higher. In every other case it lasts 8.
- R4: A work RAM access (region code 2'b01) lasts 8 master clocks.
- R5: A memory-mapped register access (region code 2'b10) lasts 6 master clocks.
- R6: A serial controller port access (region code 2'b11) lasts 12 master clocks.
- R7: The length is taken from the inputs only in the first clock of a bus cycle. Changes to the address or region later in the cycle do not alter it.
- R8: A write of the enable bit (`fast_wr` = 1) in the first clock of a bus cycle does not affect that cycle. It applies from the next bus cycle onwards.
- R9: `cycle_done` is high for exactly one clock, in the last clock of the bus cycle. The next bus cycle starts in the following clock, so consecutive strobes are exactly one cycle length apart.
- R10: A `pause_req` sampled high, with no stall active, makes the current bus cycle 40 master clocks longer. During those 40 clocks the count is frozen and `cycle_done` stays 0. This holds even when the request arrives in the second-to-last clock.
- R11: A `pause_req` raised while a stall is already running is ignored and does not lengthen the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 24 | Address of the current access |
| bus_internal | input | 1 | 1 = internal cycle with no memory access |
| bus_region | input | 2 | 00 ROM, 01 work RAM, 10 memory-mapped register, 11 serial controller port |
| fast_wr | input | 1 | Write strobe for the fast-ROM enable bit |
| fast_wdata | input | 1 | Value written to the enable bit |
| pause_req | input | 1 | Starts a 40-clock stall of the current bus cycle |
| cycle_done | output | 1 | One-clock strobe in the last clock of a bus cycle |
| cycle_len | output | 4 | Length of the bus cycle now running |
| fast_rom_en | output | 1 | Current value of the fast-ROM enable bit |

## Verification
Every result is due a known number of clocks after its stimulus:
- A bus cycle's length inputs, applied in its first clock, produce the strobe exactly that many clocks later, counting the first clock as one.
- A pause adds exactly 40 to that count.
- An enable-bit write shows on `fast_rom_en` one clock after the write and changes lengths only from the next bus cycle.

The bench applies each stimulus half a period before the edge that samples it and reads outputs at the falling edge. It counts clocks from the first clock of a cycle to the clock where the strobe appears. That count must equal the expected length exactly, so an early or late strobe fails.

// File: rtl/bct_pkg.sv
`timescale 1ns/1ps
// Package: shared region codes and bus cycle lengths for the bus cycle timer.
// Assumes: region decoding happens upstream and yields one of four codes.
package bct_pkg;
    typedef enum logic [1:0] {
        REG_ROM    = 2'b00,
        REG_WRAM   = 2'b01,
        REG_MMIO   = 2'b10,
        REG_SERIAL = 2'b11
    } region_t;

    localparam int LEN_FAST_I  = 6;
    localparam int LEN_SLOW_I  = 8;
    localparam int LEN_XSLOW_I = 12;
    localparam int CNT_W       = $clog2(LEN_XSLOW_I + 1);

    localparam logic [CNT_W-1:0] LEN_FAST  = CNT_W'(LEN_FAST_I);
    localparam logic [CNT_W-1:0] LEN_SLOW  = CNT_W'(LEN_SLOW_I);
    localparam logic [CNT_W-1:0] LEN_XSLOW = CNT_W'(LEN_XSLOW_I);
endpackage

// File: rtl/bct_len_decode.sv
`timescale 1ns/1ps
// Module: picks the master-clock length of an access from its attributes.
// Assumes: purely combinational; the caller samples the result at cycle start.
module bct_len_decode #(
    parameter int                ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] FAST_BASE = 24'h800000
) (
    input  logic                    addr_hi_ok_unused_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    internal_cyc,
    input  bct_pkg::region_t        region,
    input  logic                    fast_en,
    output logic [bct_pkg::CNT_W-1:0] len
);
    import bct_pkg::*;

    logic in_fast_window;
    assign in_fast_window = (addr >= FAST_BASE) & addr_hi_ok_unused_n;

    // Select the length: internal first, then by region.
    always_comb begin
        if (internal_cyc) begin
            len = LEN_FAST;
        end else begin
            unique case (region)
                REG_ROM:    len = (fast_en && in_fast_window) ? LEN_FAST : LEN_SLOW;
                REG_WRAM:   len = LEN_SLOW;
                REG_MMIO:   len = LEN_FAST;
                REG_SERIAL: len = LEN_XSLOW;
                default:    len = LEN_SLOW;
            endcase
        end
    end
endmodule

// File: rtl/bct_pause_timer.sv
`timescale 1ns/1ps
// Module: runs a fixed-length stall window started by a pause request.
// Assumes: requests arriving while the window is open are dropped.
module bct_pause_timer #(
    parameter int STALL_LEN = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_req,
    output logic stall
);
    localparam int SW = $clog2(STALL_LEN + 1);
    localparam logic [SW-1:0] STALL_INIT = SW'(STALL_LEN);

    logic [SW-1:0] remain;

    // Load on an idle-time request, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - SW'(1);
        end else if (pause_req) begin
            remain <= STALL_INIT;
        end
    end

    assign stall = (remain != '0);

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(pause_req)); // R10
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0) |=> ((remain + SW'(1)) == $past(remain))); // R11
endmodule

// File: rtl/bct_cycle_counter.sv
`timescale 1ns/1ps
// Module: counts master clocks through one bus cycle and flags its last clock.
// Assumes: the length input is valid in the first clock (count zero); every
//          length is at least 2, so a cycle never completes in its first clock.
module bct_cycle_counter (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hold,
    input  logic [bct_pkg::CNT_W-1:0] len_now,
    output logic [bct_pkg::CNT_W-1:0] cnt,
    output logic [bct_pkg::CNT_W-1:0] len_cur,
    output logic                      done
);
    import bct_pkg::*;

    logic [CNT_W-1:0] len_q;
    logic             first;

    assign first   = (cnt == '0);
    assign len_cur = first ? len_now : len_q;
    assign done    = !hold && !first && (cnt == len_q - CNT_W'(1));

    // Latch the length in the first clock; step or wrap the count unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_q <= LEN_SLOW;
        end else if (!hold) begin
            if (first) len_q <= len_now;
            cnt <= done ? '0 : cnt + CNT_W'(1);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cnt)); // R10
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!first && !done) |=> $stable(len_q)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (first || cnt < len_q)); // R9
endmodule

// File: rtl/bus_cycle_timer.sv
`timescale 1ns/1ps
// Module: top of the bus cycle timer. Holds the fast-ROM enable bit and ties
//         the length decoder, the pause timer and the cycle counter together.
// Assumes: synchronous active-low reset; region is decoded upstream.
module bus_cycle_timer #(
    parameter int                ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] FAST_BASE = 24'h800000,
    parameter int                STALL_LEN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_internal,
    input  logic [1:0]        bus_region,
    input  logic              fast_wr,
    input  logic              fast_wdata,
    input  logic              pause_req,
    output logic              cycle_done,
    output logic [3:0]        cycle_len,
    output logic              fast_rom_en
);
    import bct_pkg::*;

    logic             fast_q;
    logic             stall;
    logic [CNT_W-1:0] len_now;
    logic [CNT_W-1:0] len_cur;
    logic [CNT_W-1:0] cnt;

    // Fast-ROM enable register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       fast_q <= 1'b0;
        else if (fast_wr) fast_q <= fast_wdata;
    end

    bct_len_decode #(.ADDR_W(ADDR_W), .FAST_BASE(FAST_BASE)) u_dec (
        .addr_hi_ok_unused_n (1'b1),
        .addr                (bus_addr),
        .internal_cyc        (bus_internal),
        .region              (region_t'(bus_region)),
        .fast_en             (fast_q),
        .len                 (len_now)
    );

    bct_pause_timer #(.STALL_LEN(STALL_LEN)) u_pause (
        .clk       (clk),
        .rst_n     (rst_n),
        .pause_req (pause_req),
        .stall     (stall)
    );

    bct_cycle_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (stall),
        .len_now (len_now),
        .cnt     (cnt),
        .len_cur (len_cur),
        .done    (cycle_done)
    );

    assign cycle_len   = 4'(len_cur);
    assign fast_rom_en = fast_q;

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (len_cur == LEN_FAST || len_cur == LEN_SLOW || len_cur == LEN_XSLOW)); // R2
    AST_STALL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !cycle_done); // R10
    AST_SERIAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !bus_internal && bus_region == 2'b11) |-> (len_cur == LEN_XSLOW)); // R6
endmodule

// File: tb/bus_cycle_timer_bench.sv
`timescale 1ns/1ps
module bus_cycle_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_internal = 1'b0;
    logic [1:0]  bus_region = 2'b00;
    logic        fast_wr = 1'b0;
    logic        fast_wdata = 1'b0;
    logic        pause_req = 1'b0;
    logic        cycle_done;
    logic [3:0]  cycle_len;
    logic        fast_rom_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    bus_cycle_timer u_bus_cycle_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_internal(bus_internal),
        .bus_region(bus_region), .fast_wr(fast_wr), .fast_wdata(fast_wdata),
        .pause_req(pause_req), .cycle_done(cycle_done), .cycle_len(cycle_len),
        .fast_rom_en(fast_rom_en)
    );

    // vector: addr[31:8], internal[7], region[6:5], fast[4], expected[3:0]
    localparam int NV = 10;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {24'h000000, 1'b0, 2'b00, 1'b0, 4'd8},
        {24'h800000, 1'b0, 2'b00, 1'b0, 4'd8},
        {24'h800000, 1'b0, 2'b00, 1'b1, 4'd6},
        {24'h7FFFFF, 1'b0, 2'b00, 1'b1, 4'd8},
        {24'hFFFFFF, 1'b0, 2'b00, 1'b1, 4'd6},
        {24'h7E0000, 1'b0, 2'b01, 1'b1, 4'd8},
        {24'h002100, 1'b0, 2'b10, 1'b0, 4'd6},
        {24'h004016, 1'b0, 2'b11, 1'b0, 4'd12},
        {24'hC00000, 1'b1, 2'b00, 1'b0, 4'd6},
        {24'h004017, 1'b1, 2'b11, 1'b1, 4'd6}
    };

    function automatic string tag_of(input logic intl, input logic [1:0] reg_c);
        if (intl) return "R2";
        case (reg_c)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at the falling edge of a cycle's first clock, inputs already set.
    // p1/p2: clock index at which pause_req is raised; chg: index at which the
    // region/address are swapped to a serial port access.
    task automatic measure(input int p1, input int p2, input int chg, output int n);
        n = 0;
        for (int k = 0; k < 400; k++) begin
            n++;
            if (n > 1) fast_wr = 1'b0;
            if (cycle_done) break;
            pause_req = (n == p1) || (n == p2);
            if (n == chg) begin
                bus_region = 2'b11;
                bus_addr   = 24'h004016;
            end
            @(negedge clk);
        end
        pause_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_fast(input logic v);
        int n;
        bus_internal = 1'b1;
        fast_wr = 1'b1;
        fast_wdata = v;
        measure(-1, -1, -1, n);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(cycle_done), 0);
        chk("R1 enable in reset", int'(fast_rom_en), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();

        // R1: ROM high runs slow after reset
        bus_internal = 1'b0; bus_region = 2'b00; bus_addr = 24'h900000;
        measure(-1, -1, -1, n);
        chk("R1 ROM high after reset", n, 8);
        chk("R9 strobe gone next clock", int'(cycle_done), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_fast(VEC[i][4]);
            bus_addr     = VEC[i][31:8];
            bus_internal = VEC[i][7];
            bus_region   = VEC[i][6:5];
            measure(-1, -1, -1, n);
            chk(tag_of(VEC[i][7], VEC[i][6:5]), n, int'(VEC[i][3:0]));
        end

        // R8: write in first clock applies next cycle
        set_fast(1'b0);
        bus_internal = 1'b0; bus_region = 2'b00; bus_addr = 24'hA00000;
        fast_wr = 1'b1; fast_wdata = 1'b1;
        measure(-1, -1, -1, n);
        chk("R8 write cycle unchanged", n, 8);
        chk("R8 enable visible", int'(fast_rom_en), 1);
        measure(-1, -1, -1, n);
        chk("R8 next cycle fast", n, 6);

        // R9: back-to-back cycles, strobes exactly one length apart
        bus_region = 2'b10; bus_addr = 24'h002100;
        measure(-1, -1, -1, n);
        chk("R9 back to back 1", n, 6);
        measure(-1, -1, -1, n);
        chk("R9 back to back 2", n, 6);

        // R7: mid-cycle swap to serial does not alter length
        set_fast(1'b0);
        bus_internal = 1'b0; bus_region = 2'b01; bus_addr = 24'h7E0010;
        measure(-1, -1, 3, n);
        chk("R7 held length", n, 8);

        // R10: pause in first clock and in second-to-last clock
        bus_internal = 1'b0; bus_region = 2'b10; bus_addr = 24'h002100;
        measure(1, -1, -1, n);
        chk("R10 pause at start", n, 46);
        bus_region = 2'b11; bus_addr = 24'h004016;
        measure(11, -1, -1, n);
        chk("R10 pause near end", n, 52);

        // R11: second request during stall ignored
        bus_region = 2'b01; bus_addr = 24'h7E0000;
        measure(1, 12, -1, n);
        chk("R11 request in stall ignored", n, 48);

        // R1: reset clears a set enable bit
        set_fast(1'b1);
        @(negedge clk);
        do_reset();
        bus_internal = 1'b0; bus_region = 2'b00; bus_addr = 24'h800000;
        measure(-1, -1, -1, n);
        chk("R1 slow after second reset", n, 8);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule